// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Unit

This block decides, every cycle, how many instructions leave the head of the reorder buffer, always in program order. A window of the oldest `SCAN` entries is presented with per-entry flags: valid, squashed, executed, serialising (non-speculative, store-conditional or barrier), load, store and fault. The block then scans the window from the oldest entry. Squashed entries are dropped for free. Finished entries are committed, up to `WIDTH` per cycle. The scan halts at the first entry that cannot go.

The window behaves as a stream source. `win_vld` marks valid entries, and the valid bits must form a contiguous run from slot 0. The combinational `pop_cnt` acts as the ready side: the buffer removes exactly that many entries at the clock edge. Entries that are not popped must be presented again, and the block never pops an entry that is not valid. Serialising heads and unexecuted loads are handled only as the first commit of a cycle, with no stores waiting to write back. Such a head produces a one-cycle execute-request pulse. A fault head under the same conditions produces a one-cycle trap pulse and a sticky trap-pending state. The architectural PC pair, the youngest committed sequence number, an empty indication for earlier stages and a count of cycles limited by width are all kept here.

Top module: `retire_unit`

## Requirements
- R1: Each cycle the oldest entries are committed in order, at most WIDTH (default 4) in a cycle. The scan stops at the first invalid entry or unexecuted ordinary entry. It also stops once WIDTH entries have committed, even if squashed entries follow. `pop_cnt` and `commit_cnt` reflect this decision in the same cycle.
- R2: A squashed entry is popped without adding to `commit_cnt` and without changing the PC or `done_seq`.
- R3: An unexecuted serialising entry (flag `win_serial`) pops nothing and ends the scan. If it is in the first commit slot and `stores_pend` is low, `nsx_valid` pulses in the next cycle with its sequence number and `nsx_uncached`=0. Otherwise no request is made.
- R4: An unexecuted load follows the same rule as R3, except that the request carries `nsx_uncached`=1.
- R5: An executed entry with its fault flag set is never committed. If it is in the first slot and `stores_pend` is low, `trap_req` pulses in the next cycle and `trap_pend` becomes 1. Otherwise it simply stalls.
- R6: While `trap_pend` is 1, nothing is popped and no request or trap is raised. A `trap_clr` pulse clears `trap_pend` at the next edge.
- R7: After a cycle with k>0 commits, `arch_pc` = old `arch_npc` + 4(k-1) and `arch_npc` = old `arch_npc` + 4k. Reset loads `RESET_PC` and `RESET_PC`+4.
- R8: `done_seq` takes the sequence number of the youngest entry committed in the cycle. It is unchanged when nothing commits, and it is 0 after reset.
- R9: `rob_empty_rpt` is 1 in the cycle after an edge at which four things hold: every valid window entry was popped, `rob_more` was low, `stores_pend` was low and no store committed.
- R10: `bw_limit_cnt` increments by one after every cycle in which `commit_cnt` equals WIDTH.
- R11: After reset, `nsx_valid`, `trap_req`, `trap_pend`, `rob_empty_rpt` and `bw_limit_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_vld | input | SCAN | Window entry valid, slot 0 oldest |
| win_seq | input | SCAN*SEQW | Sequence numbers, slot i at bits [i*SEQW +: SEQW] |
| win_squashed | input | SCAN | Entry was squashed |
| win_executed | input | SCAN | Entry finished execution |
| win_serial | input | SCAN | Non-speculative, store-conditional or barrier |
| win_load | input | SCAN | Entry is a load |
| win_store | input | SCAN | Entry is a store |
| win_fault | input | SCAN | Entry raised a fault |
| rob_more | input | 1 | Buffer holds entries beyond the window |
| stores_pend | input | 1 | Store writeback still outstanding |
| trap_clr | input | 1 | Trap handling finished |
| pop_cnt | output | CNTW | Entries removed at this edge |
| commit_cnt | output | CNTW | Entries committed at this edge |
| nsx_valid | output | 1 | Execute-request pulse |
| nsx_seq | output | SEQW | Sequence number of the request |
| nsx_uncached | output | 1 | Request is an uncached load |
| trap_req | output | 1 | Trap pulse |
| trap_pend | output | 1 | Trap pending, retirement frozen |
| done_seq | output | SEQW | Youngest committed sequence number |
| arch_pc | output | AW | Architectural PC |
| arch_npc | output | AW | Architectural next PC |
| rob_empty_rpt | output | 1 | Empty indication for earlier stages |
| bw_limit_cnt | output | BWW | Width-limited cycle count |

## Verification
Squashed-entry retirement and the width limit can both act in one cycle. A full window is provoked in which squashed entries sit between committing ones and the fourth commit is followed by more entries. The check confirms that the pop count exceeds the commit count and that the scan stopped exactly at the limit. A store commit and an otherwise empty buffer can also meet in one cycle. The empty indication is then judged to stay low, while the same pattern without the store raises it. A serialising head behind a commit in the same cycle is checked to stall without a request.

// File: rtl/retire_pkg.sv
package retire_pkg;
  localparam int DEF_SCAN  = 8;
  localparam int DEF_WIDTH = 4;
  localparam int DEF_SEQW  = 16;
  localparam int DEF_AW    = 32;
  localparam int DEF_BWW   = 16;
  localparam int INST_BYTES = 4;

  typedef struct packed {
    logic nsx;
    logic uncached;
    logic trap;
    logic store_done;
    logic all_gone;
  } scan_evt_t;
endpackage

// File: rtl/retire_scan.sv
module retire_scan
  import retire_pkg::*;
#(
  parameter int SCAN  = DEF_SCAN,
  parameter int WIDTH = DEF_WIDTH,
  parameter int SEQW  = DEF_SEQW,
  localparam int CNTW = $clog2(SCAN + 1)
) (
  input  logic                 blocked,
  input  logic                 stores_pend,
  input  logic [SCAN-1:0]      vld,
  input  logic [SCAN*SEQW-1:0] seq,
  input  logic [SCAN-1:0]      squashed,
  input  logic [SCAN-1:0]      executed,
  input  logic [SCAN-1:0]      serial,
  input  logic [SCAN-1:0]      load,
  input  logic [SCAN-1:0]      store,
  input  logic [SCAN-1:0]      fault,
  output logic [CNTW-1:0]      pop,
  output logic [CNTW-1:0]      cmt,
  output logic [SEQW-1:0]      last_seq,
  output logic [SEQW-1:0]      req_seq,
  output scan_evt_t            evt
);
  localparam logic [CNTW-1:0] CMAX = CNTW'(WIDTH);

  logic [SCAN-1:0] popped;

  always_comb begin
    logic halt;
    halt     = blocked;
    pop      = '0;
    cmt      = '0;
    last_seq = '0;
    req_seq  = '0;
    evt      = '0;
    popped   = '0;
    for (int i = 0; i < SCAN; i++) begin
      if (!halt) begin
        if (!vld[i] || cmt == CMAX) begin
          halt = 1'b1;
        end else if (squashed[i]) begin
          pop       = pop + 1'b1;
          popped[i] = 1'b1;
        end else if (!executed[i]) begin
          if ((serial[i] || load[i]) && cmt == '0 && !stores_pend) begin
            evt.nsx      = 1'b1;
            evt.uncached = !serial[i];
            req_seq      = seq[i*SEQW +: SEQW];
          end
          halt = 1'b1;
        end else if (fault[i]) begin
          if (cmt == '0 && !stores_pend) evt.trap = 1'b1;
          halt = 1'b1;
        end else begin
          pop       = pop + 1'b1;
          cmt       = cmt + 1'b1;
          popped[i] = 1'b1;
          last_seq  = seq[i*SEQW +: SEQW];
          if (store[i]) evt.store_done = 1'b1;
        end
      end
    end
    evt.all_gone = ~|(vld & ~popped);
  end
endmodule

// File: rtl/retire_arch_state.sv
module retire_arch_state
  import retire_pkg::*;
#(
  parameter int SEQW = DEF_SEQW,
  parameter int AW   = DEF_AW,
  parameter int CNTW = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] cmt,
  input  logic [CNTW-1:0] pop,
  input  logic [SEQW-1:0] last_seq,
  input  logic [SEQW-1:0] req_seq,
  input  scan_evt_t       evt,
  input  logic            trap_clr,
  input  logic            stores_pend,
  output logic            nsx_valid,
  output logic [SEQW-1:0] nsx_seq,
  output logic            nsx_uncached,
  output logic            trap_req,
  output logic            trap_pend,
  output logic [SEQW-1:0] done_seq,
  output logic [AW-1:0]   arch_pc,
  output logic [AW-1:0]   arch_npc
);
  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic [AW-1:0] adv;
  assign adv = AW'(cmt) * STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arch_pc  <= RESET_PC;
      arch_npc <= RESET_PC + STEP;
      done_seq <= '0;
    end else if (cmt != '0) begin
      arch_pc  <= arch_npc + adv - STEP;
      arch_npc <= arch_npc + adv;
      done_seq <= last_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nsx_valid    <= 1'b0;
      nsx_seq      <= '0;
      nsx_uncached <= 1'b0;
      trap_req     <= 1'b0;
      trap_pend    <= 1'b0;
    end else begin
      nsx_valid <= evt.nsx;
      trap_req  <= evt.trap;
      if (evt.nsx) begin
        nsx_seq      <= req_seq;
        nsx_uncached <= evt.uncached;
      end
      if (trap_clr)      trap_pend <= 1'b0;
      else if (evt.trap) trap_pend <= 1'b1;
    end
  end

  assert_frozen_while_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pend |-> (pop == '0 && !evt.nsx && !evt.trap));
  assert_trap_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_pend);
  assert_request_no_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nsx_valid |-> !$past(stores_pend));
  assert_pc_pair_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmt) != '0 |-> arch_npc == arch_pc + STEP);
endmodule

// File: rtl/retire_stats.sv
module retire_stats
  import retire_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH,
  parameter int BWW   = DEF_BWW,
  parameter int CNTW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CNTW-1:0] cmt,
  input  logic [CNTW-1:0] pop,
  input  scan_evt_t       evt,
  input  logic            rob_more,
  input  logic            stores_pend,
  output logic            rob_empty_rpt,
  output logic [BWW-1:0]  bw_limit_cnt
);
  localparam logic [CNTW-1:0] CMAX = CNTW'(WIDTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rob_empty_rpt <= 1'b0;
      bw_limit_cnt  <= '0;
    end else begin
      rob_empty_rpt <= evt.all_gone && !rob_more && !stores_pend && !evt.store_done;
      if (cmt == CMAX) bw_limit_cnt <= bw_limit_cnt + 1'b1;
    end
  end

  assert_commit_within_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmt <= CMAX && pop >= cmt);
  assert_bw_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmt == CMAX |=> bw_limit_cnt == $past(bw_limit_cnt) + 1'b1);
  assert_empty_needs_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stores_pend || rob_more) |=> !rob_empty_rpt);
endmodule

// File: rtl/retire_unit.sv
module retire_unit
  import retire_pkg::*;
#(
  parameter int SCAN  = DEF_SCAN,
  parameter int WIDTH = DEF_WIDTH,
  parameter int SEQW  = DEF_SEQW,
  parameter int AW    = DEF_AW,
  parameter int BWW   = DEF_BWW,
  parameter logic [AW-1:0] RESET_PC = AW'(32'h0000_1000),
  localparam int CNTW = $clog2(SCAN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SCAN-1:0]      win_vld,
  input  logic [SCAN*SEQW-1:0] win_seq,
  input  logic [SCAN-1:0]      win_squashed,
  input  logic [SCAN-1:0]      win_executed,
  input  logic [SCAN-1:0]      win_serial,
  input  logic [SCAN-1:0]      win_load,
  input  logic [SCAN-1:0]      win_store,
  input  logic [SCAN-1:0]      win_fault,
  input  logic                 rob_more,
  input  logic                 stores_pend,
  input  logic                 trap_clr,
  output logic [CNTW-1:0]      pop_cnt,
  output logic [CNTW-1:0]      commit_cnt,
  output logic                 nsx_valid,
  output logic [SEQW-1:0]      nsx_seq,
  output logic                 nsx_uncached,
  output logic                 trap_req,
  output logic                 trap_pend,
  output logic [SEQW-1:0]      done_seq,
  output logic [AW-1:0]        arch_pc,
  output logic [AW-1:0]        arch_npc,
  output logic                 rob_empty_rpt,
  output logic [BWW-1:0]       bw_limit_cnt
);
  logic [SEQW-1:0] last_seq, req_seq;
  scan_evt_t       evt;

  retire_scan #(.SCAN(SCAN), .WIDTH(WIDTH), .SEQW(SEQW)) u_scan (
    .blocked(trap_pend), .stores_pend(stores_pend),
    .vld(win_vld), .seq(win_seq), .squashed(win_squashed),
    .executed(win_executed), .serial(win_serial), .load(win_load),
    .store(win_store), .fault(win_fault),
    .pop(pop_cnt), .cmt(commit_cnt), .last_seq(last_seq),
    .req_seq(req_seq), .evt(evt)
  );

  retire_arch_state #(.SEQW(SEQW), .AW(AW), .CNTW(CNTW), .RESET_PC(RESET_PC)) u_arch (
    .clk(clk), .rst_n(rst_n), .cmt(commit_cnt), .pop(pop_cnt),
    .last_seq(last_seq), .req_seq(req_seq), .evt(evt),
    .trap_clr(trap_clr), .stores_pend(stores_pend),
    .nsx_valid(nsx_valid), .nsx_seq(nsx_seq), .nsx_uncached(nsx_uncached),
    .trap_req(trap_req), .trap_pend(trap_pend), .done_seq(done_seq),
    .arch_pc(arch_pc), .arch_npc(arch_npc)
  );

  retire_stats #(.WIDTH(WIDTH), .BWW(BWW), .CNTW(CNTW)) u_stats (
    .clk(clk), .rst_n(rst_n), .cmt(commit_cnt), .pop(pop_cnt), .evt(evt),
    .rob_more(rob_more), .stores_pend(stores_pend),
    .rob_empty_rpt(rob_empty_rpt), .bw_limit_cnt(bw_limit_cnt)
  );
endmodule

// File: tb/tb_retire_unit.sv
module tb_retire_unit;
  localparam int S = 8;
  localparam int SEQW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [S-1:0] vld = '0, sq = '0, ex = '0, ser = '0, ld = '0, st = '0, flt = '0;
  logic [S*SEQW-1:0] seq = '0;
  logic more = 1'b0, stp = 1'b0, tclr = 1'b0;
  logic [3:0] pop_cnt, commit_cnt;
  logic nsx_valid, nsx_uncached, trap_req, trap_pend, rob_empty_rpt;
  logic [SEQW-1:0] nsx_seq, done_seq;
  logic [31:0] arch_pc, arch_npc;
  logic [15:0] bw_limit_cnt;

  int errs = 0, checks = 0;
  logic [31:0] m_npc;
  logic [SEQW-1:0] m_done;
  logic [15:0] m_bw;

  always #2 clk = ~clk;

  retire_unit dut (
    .clk(clk), .rst_n(rst_n), .win_vld(vld), .win_seq(seq), .win_squashed(sq),
    .win_executed(ex), .win_serial(ser), .win_load(ld), .win_store(st),
    .win_fault(flt), .rob_more(more), .stores_pend(stp), .trap_clr(tclr),
    .pop_cnt(pop_cnt), .commit_cnt(commit_cnt), .nsx_valid(nsx_valid),
    .nsx_seq(nsx_seq), .nsx_uncached(nsx_uncached), .trap_req(trap_req),
    .trap_pend(trap_pend), .done_seq(done_seq), .arch_pc(arch_pc),
    .arch_npc(arch_npc), .rob_empty_rpt(rob_empty_rpt), .bw_limit_cnt(bw_limit_cnt)
  );

  typedef struct packed {
    logic [7:0] vld, sq, ex, ser, ld, st, flt;
    logic stp, more;
    logic [3:0] pop, cmt;
    logic [2:0] last;
    logic nsx, unc, empty;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{8'h07,8'h00,8'h07,8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,4'd3,4'd3,3'd2,1'b0,1'b0,1'b1},
    '{8'h3F,8'h00,8'h3F,8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,4'd4,4'd4,3'd3,1'b0,1'b0,1'b0},
    '{8'hFF,8'h0A,8'hF5,8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,4'd6,4'd4,3'd5,1'b0,1'b0,1'b0},
    '{8'h0F,8'h00,8'h0B,8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,4'd2,4'd2,3'd1,1'b0,1'b0,1'b0},
    '{8'h03,8'h00,8'h02,8'h01,8'h00,8'h00,8'h00,1'b0,1'b0,4'd0,4'd0,3'd0,1'b1,1'b0,1'b0},
    '{8'h03,8'h00,8'h01,8'h02,8'h00,8'h00,8'h00,1'b0,1'b0,4'd1,4'd1,3'd0,1'b0,1'b0,1'b0},
    '{8'h01,8'h00,8'h00,8'h00,8'h01,8'h00,8'h00,1'b1,1'b0,4'd0,4'd0,3'd0,1'b0,1'b0,1'b0},
    '{8'h01,8'h00,8'h00,8'h00,8'h01,8'h00,8'h00,1'b0,1'b0,4'd0,4'd0,3'd0,1'b1,1'b1,1'b0},
    '{8'h01,8'h00,8'h01,8'h00,8'h00,8'h01,8'h00,1'b0,1'b0,4'd1,4'd1,3'd0,1'b0,1'b0,1'b0},
    '{8'h01,8'h00,8'h01,8'h00,8'h00,8'h00,8'h00,1'b1,1'b0,4'd1,4'd1,3'd0,1'b0,1'b0,1'b0},
    '{8'h03,8'h03,8'h00,8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,4'd2,4'd0,3'd0,1'b0,1'b0,1'b1},
    '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,4'd0,4'd0,3'd0,1'b0,1'b0,1'b1},
    '{8'h03,8'h00,8'h03,8'h00,8'h00,8'h00,8'h00,1'b0,1'b1,4'd2,4'd2,3'd1,1'b0,1'b0,1'b0},
    '{8'h03,8'h00,8'h03,8'h00,8'h00,8'h00,8'h02,1'b0,1'b0,4'd1,4'd1,3'd0,1'b0,1'b0,1'b0},
    '{8'h01,8'h00,8'h00,8'h01,8'h00,8'h00,8'h00,1'b1,1'b0,4'd0,4'd0,3'd0,1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic [SEQW-1:0] base);
    vld = v.vld; sq = v.sq; ex = v.ex; ser = v.ser; ld = v.ld; st = v.st; flt = v.flt;
    stp = v.stp; more = v.more;
    for (int i = 0; i < S; i++) seq[i*SEQW +: SEQW] = base + SEQW'(i);
  endtask

  // model update from requirements R7/R8/R10 after a cycle with k commits
  task automatic model(input int k, input logic [SEQW-1:0] youngest);
    if (k > 0) begin
      m_npc  = m_npc + 32'(4 * k);
      m_done = youngest;
    end
    if (k == 4) m_bw = m_bw + 1'b1;
  endtask

  task automatic chk_arch(input string tag);
    chk({tag, " R7 pc"}, arch_pc, m_npc - 32'd4);
    chk({tag, " R7 npc"}, arch_npc, m_npc);
    chk({tag, " R8 done_seq"}, 32'(done_seq), 32'(m_done));
    chk({tag, " R10 bw"}, 32'(bw_limit_cnt), 32'(m_bw));
  endtask

  initial begin
    #400000;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [SEQW-1:0] base;
    m_npc = 32'h1004; m_done = '0; m_bw = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 nsx", 32'(nsx_valid), 0);
    chk("R11 trap_req", 32'(trap_req), 0);
    chk("R11 trap_pend", 32'(trap_pend), 0);
    chk("R11 empty", 32'(rob_empty_rpt), 0);
    chk_arch("R11");
    @(negedge clk);
    rst_n = 1'b1;

    base = 16'h0100;
    for (int r = 0; r < 15; r++) begin
      vec_t v;
      v = TBL[r];
      @(negedge clk);
      drive(v, base);
      #1;
      chk($sformatf("R1 row%0d pop", r), 32'(pop_cnt), 32'(v.pop));
      chk($sformatf("R2 row%0d commit", r), 32'(commit_cnt), 32'(v.cmt));
      @(posedge clk);
      #1;
      model(int'(v.cmt), base + SEQW'(v.last));
      chk($sformatf("R3 row%0d nsx", r), 32'(nsx_valid), 32'(v.nsx));
      if (v.nsx) begin
        chk($sformatf("R3 row%0d nsx_seq", r), 32'(nsx_seq), 32'(base + SEQW'(v.pop)));
        chk($sformatf("R4 row%0d uncached", r), 32'(nsx_uncached), 32'(v.unc));
      end
      chk($sformatf("R5 row%0d no trap", r), 32'(trap_req), 0);
      chk($sformatf("R9 row%0d empty", r), 32'(rob_empty_rpt), 32'(v.empty));
      chk_arch($sformatf("row%0d", r));
      base = base + 16'h0010;
    end

    // R5: fault at head with stores pending stalls without trap
    @(negedge clk);
    drive('{8'h03,8'h00,8'h03,8'h00,8'h00,8'h00,8'h01,1'b1,1'b0,4'd0,4'd0,3'd0,1'b0,1'b0,1'b0}, 16'h0500);
    #1;
    chk("R5 fault stall pop", 32'(pop_cnt), 0);
    @(posedge clk); #1;
    chk("R5 fault stall trap", 32'(trap_req), 0);
    // R5: stores drained, trap raised
    @(negedge clk);
    stp = 1'b0;
    #1;
    chk("R5 fault pop", 32'(pop_cnt), 0);
    @(posedge clk); #1;
    chk("R5 trap_req", 32'(trap_req), 1);
    chk("R5 trap_pend", 32'(trap_pend), 1);
    chk_arch("R5");
    // R6: pending trap freezes retirement of a clean window
    @(negedge clk);
    drive('{8'h0F,8'h00,8'h0F,8'h00,8'h00,8'h00,8'h00,1'b0,1'b0,4'd0,4'd0,3'd0,1'b0,1'b0,1'b0}, 16'h0600);
    #1;
    chk("R6 frozen pop", 32'(pop_cnt), 0);
    chk("R6 frozen commit", 32'(commit_cnt), 0);
    @(posedge clk); #1;
    chk("R6 trap pulse once", 32'(trap_req), 0);
    chk("R6 still pending", 32'(trap_pend), 1);
    chk_arch("R6");
    @(negedge clk);
    tclr = 1'b1;
    @(posedge clk); #1;
    chk("R6 cleared", 32'(trap_pend), 0);
    @(negedge clk);
    tclr = 1'b0;
    #1;
    chk("R6 resumes pop", 32'(pop_cnt), 4);
    @(posedge clk); #1;
    model(4, 16'h0603);
    chk_arch("R6 resume");

    // R11: reset mid-run restores initial values
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    m_npc = 32'h1004; m_done = '0; m_bw = '0;
    chk("R11 empty after reset", 32'(rob_empty_rpt), 0);
    chk_arch("R11 rerun");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule